// File: doc/BRIEF.md
# Repeated Frame Transmit Test Scheduler

This block drives a spectral-measurement test mode in which a transmitter sends the same prepared frame again and again. Software sets an enable bit in a small control register and loads a 32-bit start-to-start interval, counted in ticks of the scheduler clock. The intended tick is one quarter of 499.2 MHz, so one tick is about 8 ns. A single transmit-start strobe then arms an endless series of one-cycle `tx_go_o` pulses, one per interval. The series runs until software writes the enable bit back to zero. If the enable bit is clear when the strobe arrives, the strobe produces one ordinary transmission.

The transmitter reports the end of each frame on `frame_done_i`. If an interval expires while the current frame is still in flight, the block raises a sticky overrun flag. It then holds the next start until the frame completes. Intervals below the legal minimum of four ticks are refused with a sticky error flag, and the block stays idle. Radio datapath, frame buffer contents and channel setup lie outside this block.

Top module: `rft_sched`

## Requirements
- R1: The control register is 16 bits wide. Bit 4 is the repeat-enable bit and is the only writable bit. All other bits read back zero whatever is written. The register is written when `cfg_wr_i`=1 and `cfg_sel_i`=0, and it reads back on `ctl_rdata_o`.
- R2: A start strobe while the enable bit is clear produces exactly one `tx_go_o` pulse, on the cycle after the strobe. No further pulses follow and `active_o` stays low.
- R3: A start strobe while the enable bit is set and the interval is at least 4 produces a `tx_go_o` pulse on the next cycle. From that cycle on, `active_o` is high.
- R4: In repeat mode, each later pulse comes exactly P cycles after the previous pulse, where P is the interval written with `cfg_wr_i`=1 and `cfg_sel_i`=1. The interval is measured start to start. P=124800 therefore gives one pulse per millisecond at the 124.8 MHz tick.
- R5: An interval below 4 produces no pulse, whether it is found at the start strobe or at a boundary. In that case `per_err_o` is set and stays set until reset, and the block is idle.
- R6: Suppose a boundary is reached while the last frame is outstanding, meaning no `frame_done_i` since its pulse and none in the boundary cycle. Then `overrun_o` is set and stays set until reset. The next pulse follows one cycle after `frame_done_i`. A `frame_done_i` that falls in the boundary cycle itself counts as on time.
- R7: A write that clears the enable bit suppresses any pulse from that write's cycle onward, and `active_o` is low on the next cycle.
- R8: An interval written during repeat mode takes effect from the next pulse onward. The interval already being counted is unchanged.
- R9: A start strobe during repeat mode is ignored, and the pulse spacing is unchanged.
- R10: After reset, all outputs are zero, the control register reads zero and the interval is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | Register select: 0 control, 1 interval |
| cfg_wdata_i | input | 32 | Write data |
| start_i | input | 1 | Transmit-start strobe |
| frame_done_i | input | 1 | Frame finished pulse from the transmitter |
| ctl_rdata_o | output | 16 | Control register read value |
| tx_go_o | output | 1 | One-cycle frame-start pulse |
| active_o | output | 1 | Repeat mode running |
| per_err_o | output | 1 | Sticky illegal-interval flag |
| overrun_o | output | 1 | Sticky late-frame flag |

## Verification
Two pairs of events can fall on the same clock edge. The first pair is a period boundary and a `frame_done_i` pulse. The bench provokes it by answering each pulse with a done delay of P-1 cycles, which lands on the boundary; the expected result is clean P spacing with no overrun. Against that, a delay of P cycles must give overrun and a spacing of P+1. The second pair is a boundary and an enable-clearing write: the write is placed so it is sampled on the boundary edge, and no pulse may appear there.

// File: rtl/rft_pkg.sv
package rft_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_WAIT = 2'd2
   } rft_state_e;

   localparam int unsigned RFT_CTL_W_DEF   = 16;
   localparam int unsigned RFT_ENA_BIT_DEF = 4;
   localparam int unsigned RFT_PER_W_DEF   = 32;
   localparam int unsigned RFT_MIN_PER_DEF = 4;
endpackage

// File: rtl/rft_cfg_regs.sv
module rft_cfg_regs #(
   parameter int unsigned CTL_W   = 16,
   parameter int unsigned ENA_BIT = 4,
   parameter int unsigned PER_W   = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic             sel_i,
   input  logic [PER_W-1:0] wdata_i,
   output logic [CTL_W-1:0] ctl_o,
   output logic             ena_q_o,
   output logic             ena_nx_o,
   output logic [PER_W-1:0] period_o
);
   localparam logic [CTL_W-1:0] ENA_MASK = CTL_W'(1) << ENA_BIT;

   logic             ctl_wr;
   logic             per_wr;
   logic [CTL_W-1:0] ctl_bits;
   logic [PER_W-1:0] period_q;

   assign ctl_wr = wr_i && !sel_i;
   assign per_wr = wr_i && sel_i;

   if (ENA_BIT >= CTL_W) begin : g_bad_ena
      $error("rft_cfg_regs: ENA_BIT outside control register");
   end
   if (PER_W < CTL_W) begin : g_bad_w
      $error("rft_cfg_regs: PER_W must cover the control width");
   end

   for (genvar i = 0; i < CTL_W; i++) begin : g_bit
      if (ENA_MASK[i]) begin : g_ena
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      bit_q <= 1'b0;
            else if (ctl_wr) bit_q <= wdata_i[i];
         end
         assign ctl_bits[i] = bit_q;
      end else begin : g_rsv
         assign ctl_bits[i] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      period_q <= '0;
      else if (per_wr) period_q <= wdata_i;
   end

   assign ctl_o    = ctl_bits;
   assign ena_q_o  = ctl_bits[ENA_BIT];
   assign ena_nx_o = ctl_wr ? wdata_i[ENA_BIT] : ctl_bits[ENA_BIT];
   assign period_o = period_q;
endmodule

// File: rtl/rft_period_timer.sv
module rft_period_timer #(
   parameter int unsigned PER_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             load_i,
   input  logic             run_i,
   input  logic [PER_W-1:0] period_i,
   output logic             hit_o
);
   localparam logic [PER_W-1:0] ONE = PER_W'(1);

   logic [PER_W-1:0] cnt_q;
   logic [PER_W-1:0] lim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= ONE;
         lim_q <= period_i;
      end else if (run_i && cnt_q != lim_q) begin
         cnt_q <= cnt_q + ONE;
      end
   end

   assign hit_o = run_i && (cnt_q == lim_q);
endmodule

// File: rtl/rft_seq.sv
module rft_seq
   import rft_pkg::*;
#(
   parameter int unsigned PER_W      = 32,
   parameter int unsigned MIN_PERIOD = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ena_q_i,
   input  logic             ena_nx_i,
   input  logic             start_i,
   input  logic             done_i,
   input  logic             hit_i,
   input  logic [PER_W-1:0] period_i,
   output logic             fire_o,
   output logic             tmr_clr_o,
   output logic             tmr_run_o,
   output logic             tx_go_o,
   output logic             active_o,
   output logic             err_o,
   output logic             ovr_o
);
   localparam logic [PER_W-1:0] MIN_P = PER_W'(MIN_PERIOD);

   rft_state_e state_q, state_nx;
   logic       inflight_q, go_q, err_q, ovr_q;
   logic       per_ok, fire, err_set, ovr_set;

   assign per_ok = (period_i >= MIN_P);

   always_comb begin
      state_nx = state_q;
      fire     = 1'b0;
      err_set  = 1'b0;
      ovr_set  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               if (ena_q_i && ena_nx_i) begin
                  if (per_ok) begin
                     fire     = 1'b1;
                     state_nx = ST_RUN;
                  end else begin
                     err_set = 1'b1;
                  end
               end else begin
                  fire = 1'b1;
               end
            end
         end
         ST_RUN: begin
            if (!ena_nx_i) begin
               state_nx = ST_IDLE;
            end else if (hit_i) begin
               if (inflight_q && !done_i) begin
                  ovr_set  = 1'b1;
                  state_nx = ST_WAIT;
               end else if (per_ok) begin
                  fire = 1'b1;
               end else begin
                  err_set  = 1'b1;
                  state_nx = ST_IDLE;
               end
            end
         end
         ST_WAIT: begin
            if (!ena_nx_i) begin
               state_nx = ST_IDLE;
            end else if (done_i) begin
               if (per_ok) begin
                  fire     = 1'b1;
                  state_nx = ST_RUN;
               end else begin
                  err_set  = 1'b1;
                  state_nx = ST_IDLE;
               end
            end
         end
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         inflight_q <= 1'b0;
         go_q       <= 1'b0;
         err_q      <= 1'b0;
         ovr_q      <= 1'b0;
      end else begin
         state_q <= state_nx;
         go_q    <= fire;
         if (fire)        inflight_q <= 1'b1;
         else if (done_i) inflight_q <= 1'b0;
         if (err_set) err_q <= 1'b1;
         if (ovr_set) ovr_q <= 1'b1;
      end
   end

   assign fire_o    = fire;
   assign tmr_clr_o = (state_nx == ST_IDLE);
   assign tmr_run_o = (state_q == ST_RUN);
   assign tx_go_o   = go_q;
   assign active_o  = (state_q != ST_IDLE);
   assign err_o     = err_q;
   assign ovr_o     = ovr_q;
endmodule

// File: rtl/rft_sched.sv
module rft_sched #(
   parameter int unsigned CTL_W      = 16,
   parameter int unsigned ENA_BIT    = 4,
   parameter int unsigned PER_W      = 32,
   parameter int unsigned MIN_PERIOD = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr_i,
   input  logic             cfg_sel_i,
   input  logic [PER_W-1:0] cfg_wdata_i,
   input  logic             start_i,
   input  logic             frame_done_i,
   output logic [CTL_W-1:0] ctl_rdata_o,
   output logic             tx_go_o,
   output logic             active_o,
   output logic             per_err_o,
   output logic             overrun_o
);
   if (MIN_PERIOD < 2) begin : g_bad_min
      $error("rft_sched: MIN_PERIOD must be at least 2");
   end

   logic             ena_q, ena_nx;
   logic [PER_W-1:0] period;
   logic             fire, tmr_clr, tmr_run, hit;

   rft_cfg_regs #(.CTL_W(CTL_W), .ENA_BIT(ENA_BIT), .PER_W(PER_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (cfg_wr_i),
      .sel_i    (cfg_sel_i),
      .wdata_i  (cfg_wdata_i),
      .ctl_o    (ctl_rdata_o),
      .ena_q_o  (ena_q),
      .ena_nx_o (ena_nx),
      .period_o (period)
   );

   rft_period_timer #(.PER_W(PER_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (tmr_clr),
      .load_i   (fire),
      .run_i    (tmr_run),
      .period_i (period),
      .hit_o    (hit)
   );

   rft_seq #(.PER_W(PER_W), .MIN_PERIOD(MIN_PERIOD)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ena_q_i   (ena_q),
      .ena_nx_i  (ena_nx),
      .start_i   (start_i),
      .done_i    (frame_done_i),
      .hit_i     (hit),
      .period_i  (period),
      .fire_o    (fire),
      .tmr_clr_o (tmr_clr),
      .tmr_run_o (tmr_run),
      .tx_go_o   (tx_go_o),
      .active_o  (active_o),
      .err_o     (per_err_o),
      .ovr_o     (overrun_o)
   );
endmodule

// File: rtl/rft_sched_chk.sv
module rft_sched_chk #(
   parameter int unsigned CTL_W   = 16,
   parameter int unsigned ENA_BIT = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [CTL_W-1:0] ctl_rdata_o,
   input logic             tx_go_o,
   input logic             active_o,
   input logic             per_err_o,
   input logic             overrun_o
);
   // R2
   single_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !active_o && !ctl_rdata_o[ENA_BIT] |=> tx_go_o && !active_o);

   // R7
   off_is_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rdata_o[ENA_BIT] |-> !active_o);

   // R4
   repeat_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_go_o && active_o |=> !tx_go_o);

   // R5
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      per_err_o |=> per_err_o);

   // R5
   err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(per_err_o) |-> !active_o && !tx_go_o);

   // R6
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_o |=> overrun_o);

   // R6
   ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun_o) |-> active_o && !tx_go_o);
endmodule

bind rft_sched rft_sched_chk #(.CTL_W(CTL_W), .ENA_BIT(ENA_BIT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .ctl_rdata_o (ctl_rdata_o),
   .tx_go_o     (tx_go_o),
   .active_o    (active_o),
   .per_err_o   (per_err_o),
   .overrun_o   (overrun_o)
);

// File: tb/rft_sched_test.sv
`timescale 1ns/1ps
module rft_sched_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_i = 1'b0, cfg_sel_i = 1'b0;
   logic [31:0] cfg_wdata_i = '0;
   logic        start_i = 1'b0, frame_done_i = 1'b0;
   logic [15:0] ctl_rdata_o;
   logic        tx_go_o, active_o, per_err_o, overrun_o;

   int n_tests = 0, n_fail = 0;
   int cyc = 0, np = 0, pend = -1, done_dly = 1, ts = 0;
   bit auto_done = 1'b0;
   int pt [64];

   always #2.5 clk = ~clk;

   rft_sched uut (.*);

   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         frame_done_i = auto_done && (cyc == pend);
         if (tx_go_o) begin
            if (np < 64) pt[np] = cyc;
            np++;
            pend = cyc + done_dly;
         end
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input bit sel, input logic [31:0] d);
      @(negedge clk); #1;
      cfg_wr_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
      @(negedge clk); #1;
      cfg_wr_i = 1'b0;
   endtask

   task automatic strobe();
      @(negedge clk); #1;
      start_i = 1'b1; ts = cyc;
      @(negedge clk); #1;
      start_i = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(negedge clk); #1; end
   endtask

   task automatic wait_np(input int n, input int lim);
      for (int g = 0; g < lim && np < n; g++) begin @(negedge clk); #1; end
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) begin @(negedge clk); #1; end
   endtask

   task automatic do_reset();
      @(negedge clk); #1;
      rst_n = 1'b0; auto_done = 1'b0; pend = -1; done_dly = 1;
      idle(3);
      rst_n = 1'b1; np = 0;
      idle(1);
   endtask

   task automatic arm(input int p, input int dly);
      do_reset();
      auto_done = 1'b1; done_dly = dly;
      wr(1'b1, p);
      wr(1'b0, 32'h10);
      np = 0;
      strobe();
   endtask

   initial begin
      #(190000 * 5);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      // R10 reset state
      do_reset();
      check(ctl_rdata_o == 0 && !tx_go_o && !active_o && !per_err_o && !overrun_o,
            "R10 reset outputs", ctl_rdata_o, 0);

      // R1 control register masking
      wr(1'b0, 32'hFFFF_FFFF);
      check(ctl_rdata_o == 16'h0010, "R1 all-ones write", ctl_rdata_o, 16);
      wr(1'b0, 32'hFFFF_FFEF);
      check(ctl_rdata_o == 16'h0000, "R1 enable clear", ctl_rdata_o, 0);

      // R10 interval resets to zero: a repeat start with no interval write is refused
      do_reset();
      wr(1'b0, 32'h10);
      strobe(); idle(5);
      check(per_err_o && np == 0, "R10 interval reset zero", np, 0);

      // R2 single transmission
      do_reset();
      auto_done = 1'b1;
      strobe(); idle(20);
      check(np == 1, "R2 pulse count", np, 1);
      check(pt[0] == ts + 1, "R2 pulse cycle", pt[0], ts + 1);
      check(!active_o, "R2 stays idle", active_o, 0);

      // R3 R4 R9 sweep of legal intervals
      for (int p = 4; p <= 12; p++) begin
         arm(p, 1);
         check(pt[0] == ts + 1, "R3 first pulse", pt[0], ts + 1);
         check(active_o, "R3 active", active_o, 1);
         wait_np(2, 100);
         strobe();
         wait_np(5, 200);
         for (int i = 1; i < 5; i++)
            check(pt[i] - pt[i-1] == p, "R4 R9 spacing", pt[i] - pt[i-1], p);
         check(!overrun_o && !per_err_o, "R4 no flags", overrun_o, 0);
      end

      // R5 illegal intervals at start
      for (int p = 0; p < 4; p++) begin
         arm(p, 1);
         idle(12);
         check(np == 0, "R5 no pulse", np, 0);
         check(per_err_o && !active_o, "R5 error idle", per_err_o, 1);
      end

      // R5 illegal interval found at boundary
      arm(5, 1);
      wait_until(pt[0] + 1);
      wr(1'b1, 2);
      idle(20);
      check(np == 1 && per_err_o && !active_o, "R5 boundary refuse", np, 1);

      // R6 overrun with late frame
      arm(6, 10);
      wait_np(3, 100);
      check(pt[1] - pt[0] == 11, "R6 delayed pulse", pt[1] - pt[0], 11);
      check(pt[2] - pt[1] == 11, "R6 delayed pulse 2", pt[2] - pt[1], 11);
      check(overrun_o, "R6 overrun set", overrun_o, 1);

      // R6 done exactly in boundary cycle
      arm(6, 5);
      wait_np(4, 100);
      check(pt[3] - pt[2] == 6 && pt[1] - pt[0] == 6, "R6 coincident done", pt[1] - pt[0], 6);
      check(!overrun_o, "R6 coincident no overrun", overrun_o, 0);

      // R6 done one cycle after boundary
      arm(6, 6);
      wait_np(3, 100);
      check(pt[1] - pt[0] == 7, "R6 one late", pt[1] - pt[0], 7);
      check(overrun_o, "R6 one late flag", overrun_o, 1);

      // R7 clear sampled on the boundary edge
      arm(5, 1);
      wait_until(pt[0] + 3);
      wr(1'b0, 32'h0);
      idle(30);
      check(np == 1, "R7 no pulse after clear", np, 1);
      check(!active_o, "R7 idle", active_o, 1'b0);

      // R7 clear mid-interval
      arm(7, 1);
      wait_np(2, 50);
      wr(1'b0, 32'h0);
      idle(30);
      check(np == 2 && !active_o, "R7 mid clear", np, 2);

      // R8 interval change during run
      arm(5, 1);
      wait_until(pt[0] + 1);
      wr(1'b1, 8);
      wait_np(4, 100);
      check(pt[1] - pt[0] == 5, "R8 old interval kept", pt[1] - pt[0], 5);
      check(pt[2] - pt[1] == 8, "R8 new interval", pt[2] - pt[1], 8);
      check(pt[3] - pt[2] == 8, "R8 new interval 2", pt[3] - pt[2], 8);

      // R4 one pulse per millisecond
      arm(124800, 1);
      wait_np(2, 130000);
      check(np >= 2 && pt[1] - pt[0] == 124800, "R4 millisecond", pt[1] - pt[0], 124800);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule